// File: doc/BRIEF.md
# GPIO Interrupt Detection Unit

This unit samples sixteen general-purpose input pins and converts the lower thirteen of them into latched interrupt requests. Each pin first passes through a two-stage synchroniser. A per-pin trigger detector then compares the synchronised level with the level seen one cycle earlier. A pending bit latches each detected event and holds it until software acknowledges it. One summary line, `irq_o`, is asserted while any pending bit is set. Masking and priority are left to a downstream interrupt controller.

Software uses a small word-addressed register port with a two-bit select. It can read the synchronised pin levels, program a three-bit trigger mode for each interrupt-capable pin, and read or acknowledge the pending bits. An acknowledgement writes a one to a pending bit. It removes the bit only when the trigger condition is absent in that cycle, so a pin held at its active level keeps requesting service.

Top module: `gpio_irq_detect`

## Requirements
- R1: Select 0 reads the synchronised levels of pins 15..0 in bits 15..0 and zero in bits 31..16. A write to select 0 changes nothing.
- R2: Trigger modes use three bits: 000 level high, 001 level low, 010 rising edge, 011 falling edge, 1xx any transition. Select 2 holds the modes of pins 0..7, with pin n in bits 3n+2..3n. Select 3 holds pins 8..12 the same way (pin n in bits 3(n-8)+2..3(n-8)). Unused bits read zero, and written modes read back.
- R3: In level-high mode a pin that is 1 sets its pending bit. In level-low mode a pin that is 0 sets it.
- R4: In rising mode only a 0-to-1 change sets the pending bit. In falling mode only a 1-to-0 change sets it.
- R5: In transitional mode a change in either direction sets the pending bit.
- R6: Select 1 reads pending bits 12..0, and bits 31..13 always read zero. Pins 13..15 never raise an interrupt.
- R7: Writing 1 to a pending bit clears it only if that pin's trigger condition is absent in the write cycle. Otherwise the bit stays set.
- R8: When a trigger event and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when at least one pending bit is set.
- R10: Changing a pin's trigger mode does not by itself create a pending event.
- R11: After reset all pending bits, all modes and all register reads are zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Asynchronous general-purpose input pins |
| reg_addr | input | 2 | Register select: 0 levels, 1 pending, 2 modes 0..7, 3 modes 8..12 |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Summary interrupt request |

## Verification
The bound checker watches the pending register against the detector outputs and the clear strobes on every cycle. It checks that a fired trigger always leaves its bit set, even against a clear in the same cycle. It checks that a clear with no trigger empties the bit and that a bit never rises without a trigger. On every cycle it also confirms that the summary line agrees with the pending read and that the reserved read bits stay zero. Only the bench scenarios can show that each mode reacts to the right pin pattern through the synchroniser, that a held level survives acknowledgement, and that a mode rewrite creates no event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MODE_W = 3;

  localparam logic [1:0] SEL_LEVEL  = 2'd0;
  localparam logic [1:0] SEL_STATUS = 2'd1;
  localparam logic [1:0] SEL_TYPE0  = 2'd2;
  localparam logic [1:0] SEL_TYPE1  = 2'd3;

  // Trigger evaluation for one pin: cur is this cycle's synchronised
  // sample, prv the one before it.
  function automatic logic trig_fire(input logic [MODE_W-1:0] mode,
                                     input logic cur,
                                     input logic prv);
    logic hit;
    if (mode[2]) begin
      hit = cur ^ prv;
    end else begin
      case (mode[1:0])
        2'b00:   hit = cur;
        2'b01:   hit = ~cur;
        2'b10:   hit = cur & ~prv;
        default: hit = ~cur & prv;
      endcase
    end
    return hit;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cur_i,
  input  logic              mode_we_i,
  input  logic [MODE_W-1:0] mode_wd_i,
  input  logic              clr_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              cond_o,
  output logic              pend_o
);
  logic [MODE_W-1:0] mode_q;
  logic              prv_q;
  logic              pend_q;

  assign cond_o = trig_fire(mode_q, cur_i, prv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      prv_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (mode_we_i) begin
        mode_q <= mode_wd_i;
      end
      // The history sample is reloaded with the present level every cycle,
      // a mode write included, so the new mode never sees a stale edge.
      prv_q  <= cur_i;
      // A live condition overrides any clear arriving in the same cycle.
      pend_q <= cond_o | (pend_q & ~clr_i);
    end
  end

  assign mode_o = mode_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS  = 16,
  parameter int NUM_IRQ   = 13,
  parameter int SLOTS     = 8,
  parameter int DATA_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_o
);
  localparam int NUM_TREG = (NUM_IRQ + SLOTS - 1) / SLOTS;

  logic [NUM_PINS-1:0] lvl;
  logic [NUM_IRQ-1:0]  cond_w;
  logic [NUM_IRQ-1:0]  clr_w;
  logic [NUM_IRQ-1:0]  pend_q;
  logic [MODE_W-1:0]   mode_q [NUM_IRQ];
  logic [DATA_W-1:0]   type_rd [NUM_TREG];

  gpio_sync #(.W(NUM_PINS)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (lvl)
  );

  assign clr_w = (reg_wr && reg_addr == SEL_STATUS) ? reg_wdata[NUM_IRQ-1:0] : '0;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_cell
    localparam int         REG_IDX = i / SLOTS;
    localparam int         LSB     = (i % SLOTS) * MODE_W;
    localparam logic [1:0] SEL     = 2'(int'(SEL_TYPE0) + REG_IDX);
    logic we;
    assign we = reg_wr && (reg_addr == SEL);
    gpio_irq_cell cell_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur_i     (lvl[i]),
      .mode_we_i (we),
      .mode_wd_i (reg_wdata[LSB +: MODE_W]),
      .clr_i     (clr_w[i]),
      .mode_o    (mode_q[i]),
      .cond_o    (cond_w[i]),
      .pend_o    (pend_q[i])
    );
  end

  always_comb begin
    for (int r = 0; r < NUM_TREG; r++) type_rd[r] = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      type_rd[i / SLOTS][(i % SLOTS) * MODE_W +: MODE_W] = mode_q[i];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_LEVEL:  reg_rdata[NUM_PINS-1:0] = lvl;
      SEL_STATUS: reg_rdata[NUM_IRQ-1:0]  = pend_q;
      SEL_TYPE0:  reg_rdata = type_rd[0];
      default:    reg_rdata = type_rd[NUM_TREG-1];
    endcase
  end

  assign irq_o = |pend_q;
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int NUM_PINS = 16,
  parameter int NUM_IRQ  = 13,
  parameter int DATA_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_rdata,
  input logic               irq_o,
  input logic [NUM_IRQ-1:0] cond_w,
  input logic [NUM_IRQ-1:0] clr_w,
  input logic [NUM_IRQ-1:0] pend_q
);
  AST_LEVEL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[DATA_W-1:NUM_PINS] == '0)); // R1

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[DATA_W-1:NUM_IRQ] == '0)); // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(clr_w & ~cond_w)) == '0)); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(cond_w) & ~pend_q) == '0)); // R8

  AST_NO_SET_WITHOUT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cond_w)) == '0)); // R10

  AST_SUMMARY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (irq_o == (|reg_rdata[NUM_IRQ-1:0]))); // R9
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_IRQ  (NUM_IRQ),
  .DATA_W   (DATA_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .irq_o     (irq_o),
  .cond_w    (cond_w),
  .clr_w     (clr_w),
  .pend_q    (pend_q)
);

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_i = '0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] tlo = '0;
  logic [31:0] thi = '0;

  always #4 clk = ~clk;

  gpio_irq_detect dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  // Monitor: takes expected items off the scoreboard and compares.
  initial begin
    forever begin
      sb_item_t it;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      n_chk++;
      if (it.is_irq) begin
        if (irq_o !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s: irq_o actual %0b expected %0b", it.tag, irq_o, it.exp[0]);
        end
      end else if (reg_rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: sel %0d read actual 0x%08h expected 0x%08h",
                 it.tag, reg_addr, reg_rdata, it.exp);
      end
    end
  end

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic expect_rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    reg_addr = sel;
    #1;
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_irq(input logic exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    #1;
    it.is_irq = 1'b1; it.exp = {31'b0, exp}; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = sel;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(negedge clk);
    pin_i[idx] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    expect_rd(2'd0, 32'h0, "R11 level");
    expect_rd(2'd1, 32'h0, "R11 status");
    expect_rd(2'd2, 32'h0, "R11 type0");
    expect_rd(2'd3, 32'h0, "R11 type1");
    expect_irq(1'b0, "R11 irq");

    // Level-high pin 3 (mode 000 after reset)
    set_pin(3, 1'b1);
    expect_rd(2'd0, 32'h8, "R1 level pin3");
    expect_rd(2'd1, 32'h8, "R3 level-high pending");
    expect_irq(1'b1, "R9 irq high");
    wr(2'd1, 32'h8);
    expect_rd(2'd1, 32'h8, "R7 clear refused while high");
    set_pin(3, 1'b0);
    expect_rd(2'd1, 32'h8, "R3 latched after release");
    wr(2'd1, 32'h8);
    expect_rd(2'd1, 32'h0, "R7 clear accepted");
    expect_irq(1'b0, "R9 irq low");

    // Level-low pin 5
    tlo = 32'h1 << 15;
    wr(2'd2, tlo);
    expect_rd(2'd2, tlo, "R2 type0 readback");
    repeat (3) @(negedge clk);
    expect_rd(2'd1, 32'h20, "R3 level-low pending");
    wr(2'd1, 32'h20);
    expect_rd(2'd1, 32'h20, "R7 level-low held");
    set_pin(5, 1'b1);
    wr(2'd1, 32'h20);
    expect_rd(2'd1, 32'h0, "R7 level-low cleared");

    // Rising pin 8, falling pin 12
    thi = 32'h3002;
    wr(2'd3, thi);
    expect_rd(2'd3, thi, "R2 type1 readback");
    set_pin(8, 1'b1);
    expect_rd(2'd1, 32'h100, "R4 rising pending");
    wr(2'd1, 32'h100);
    expect_rd(2'd1, 32'h0, "R4 edge cleared while pin high");
    set_pin(12, 1'b1);
    expect_rd(2'd1, 32'h0, "R4 falling ignores rise");
    set_pin(12, 1'b0);
    expect_rd(2'd1, 32'h1000, "R4 falling pending");
    wr(2'd1, 32'h1000);
    set_pin(8, 1'b0);
    expect_rd(2'd1, 32'h0, "R4 rising ignores fall");

    // Transitional pin 0
    tlo = tlo | 32'h4;
    wr(2'd2, tlo);
    set_pin(0, 1'b1);
    expect_rd(2'd1, 32'h1, "R5 transition up");
    wr(2'd1, 32'h1);
    expect_rd(2'd1, 32'h0, "R5 cleared");
    set_pin(0, 1'b0);
    expect_rd(2'd1, 32'h1, "R5 transition down");
    wr(2'd1, 32'h1);

    // Non-interrupt pins and reserved bits
    set_pin(13, 1'b1);
    set_pin(14, 1'b1);
    expect_rd(2'd0, 32'h6020, "R1 level pins 5 13 14");
    expect_rd(2'd1, 32'h0, "R6 pins 13 14 never pend");
    wr(2'd0, 32'hFFFF_FFFF);
    expect_rd(2'd0, 32'h6020, "R1 write ignored");
    wr(2'd1, 32'hFFFF_E000);
    expect_rd(2'd1, 32'h0, "R6 reserved status zero");
    wr(2'd2, 32'hFFFF_FFFF);
    expect_rd(2'd2, 32'h00FF_FFFF, "R2 type0 unused zero");
    wr(2'd3, 32'hFFFF_FFFF);
    expect_rd(2'd3, 32'h0000_7FFF, "R2 type1 unused zero");
    wr(2'd2, tlo);
    wr(2'd3, thi);
    repeat (3) @(negedge clk);
    expect_rd(2'd1, 32'h0, "R10 mode rewrites create no event");

    // Mode change on a high pin
    tlo = tlo | (32'h3 << 18);
    wr(2'd2, tlo);
    set_pin(6, 1'b1);
    expect_rd(2'd1, 32'h0, "R4 falling pin6 ignores rise");
    tlo = (tlo & ~(32'h7 << 18)) | (32'h4 << 18);
    wr(2'd2, tlo);
    repeat (3) @(negedge clk);
    expect_rd(2'd1, 32'h0, "R10 switch to transitional no event");
    set_pin(6, 1'b0);
    expect_rd(2'd1, 32'h40, "R5 pin6 transition after switch");
    wr(2'd1, 32'h40);

    // Repeated clears against a live level
    set_pin(3, 1'b1);
    wr(2'd1, 32'h8);
    wr(2'd1, 32'h8);
    wr(2'd1, 32'h8);
    expect_rd(2'd1, 32'h8, "R7 R8 live level beats clears");
    expect_irq(1'b1, "R9 irq with pin3");
    set_pin(3, 1'b0);
    wr(2'd1, 32'h8);
    expect_rd(2'd1, 32'h0, "R7 final clear");
    expect_irq(1'b0, "R9 irq final");

    report();
  end
endmodule